// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter with Fixed or Rotating Priority

This block chooses which of four DMA channels owns a shared on-chip bus. Each channel raises a request line. A mode input picks the ordering. In fixed mode the lowest-numbered requester always wins. In rotating mode the channel that finished a transfer most recently drops to the bottom of the order, and the channels after it move up in a ring.

The winner is granted with a one-hot vector, its encoded index and a valid flag. It keeps the bus until the owning channel pulses the transfer-done strobe. The grant is released on the next edge. A new choice is made on the edge after that, once the bus is seen as free.

A pointer to the last channel served is updated on every completed transfer, whatever the mode. It is kept when the mode changes, so a switch to rotating mode starts from the channel that really went last.

Top module: `dma_chan_arb`

## Requirements
- R1: After reset, `gnt_o` is 0, `gnt_valid_o` is 0 and `gnt_idx_o` is 0.
- R2: With `rotate_i` = 0, the grant goes to the lowest-numbered requesting channel, whatever channel was served last.
- R3: With `rotate_i` = 1, after channel L has completed a transfer, the order is L+1, L+2, ... wrapping modulo 4, and L comes last.
- R4: Out of reset the last-served pointer holds channel 3, so the first rotating choice follows the order 0, 1, 2, 3.
- R5: The last-served pointer changes only when `xfer_done_i` is high while a grant is held. A done pulse while idle has no effect on any later choice.
- R6: While a grant is held and `xfer_done_i` is low, `gnt_o` and `gnt_idx_o` stay unchanged, whatever `req_i` does. The grant drops on the edge where `xfer_done_i` is sampled high.
- R7: When the bus is free and `req_i` is 0, no grant is issued.
- R8: The pointer is also updated while `rotate_i` = 0. A later switch to rotating mode ranks the channel served last in fixed mode lowest.
- R9: A grant appears one clock edge after a free-bus cycle with a nonzero `req_i`. `gnt_o` is one-hot, bit i is channel i, `gnt_idx_o` is its binary index, and `gnt_valid_o` is high exactly when `gnt_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Request line per channel, bit i is channel i |
| rotate_i | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| xfer_done_i | input | 1 | Single-cycle strobe that ends the granted transfer |
| gnt_o | output | 4 | One-hot grant |
| gnt_idx_o | output | 2 | Index of the granted channel |
| gnt_valid_o | output | 1 | A grant is held |

## Verification
The checker assumes that `xfer_done_i` belongs to the channel that holds the grant. It also assumes that a request is only compared against the grant one edge after a free-bus cycle.

The bench changes `req_i`, `rotate_i` and `xfer_done_i` only on the falling clock edge. It raises the done strobe only while a grant is held, with one exception: the R5 scenario pulses it deliberately while the bus is idle. The bench lets at least one free cycle pass between transfers, as the protocol requires.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int unsigned ARB_CH    = 4;
    localparam int unsigned ARB_IDX_W = $clog2(ARB_CH);

    typedef enum logic {
        MODE_FIXED  = 1'b0,
        MODE_ROTATE = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/dma_arb_pick.sv
// Ring search: the channel after start_i has top priority, start_i itself the lowest.
module dma_arb_pick #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [IDX_W-1:0]  start_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  win_o
);
    always_comb begin
        hit_o = |req_i;
        win_o = '0;
        // walk from lowest priority to highest; the last match wins
        for (int k = NUM_CH; k >= 1; k--) begin
            int unsigned c;
            c = (int'(start_i) + k) % NUM_CH;
            if (req_i[c]) win_o = IDX_W'(c);
        end
    end
endmodule

// File: rtl/dma_arb_onehot.sv
module dma_arb_onehot #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
    input  logic              en_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [NUM_CH-1:0] oh_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
        assign oh_o[g] = en_i && (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = ARB_CH,
    parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              rotate_i,
    input  logic              xfer_done_i,
    output logic [NUM_CH-1:0] gnt_o,
    output logic [IDX_W-1:0]  gnt_idx_o,
    output logic              gnt_valid_o
);
    localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
    } arb_state_t;

    arb_state_t       st_d, st_q;
    arb_mode_e        mode;
    logic [IDX_W-1:0] start;
    logic             hit;
    logic [IDX_W-1:0] win;

    assign mode  = arb_mode_e'(rotate_i);
    // fixed priority is the ring search started just after the last channel
    assign start = (mode == MODE_ROTATE) ? st_q.last : LAST_CH;

    dma_arb_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .req_i   (req_i),
        .start_i (start),
        .hit_o   (hit),
        .win_o   (win)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (xfer_done_i) begin
                st_d.busy = 1'b0;
                st_d.last = st_q.idx;
            end
        end else if (hit) begin
            st_d.busy = 1'b1;
            st_d.idx  = win;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{busy: 1'b0, idx: '0, last: LAST_CH};
        end else begin
            st_q <= st_d;
        end
    end

    dma_arb_onehot #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_oh (
        .en_i  (st_q.busy),
        .idx_i (st_q.idx),
        .oh_o  (gnt_o)
    );

    assign gnt_idx_o   = st_q.idx;
    assign gnt_valid_o = st_q.busy;
endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_CH-1:0] req_i,
    input logic              rotate_i,
    input logic              xfer_done_i,
    input logic [NUM_CH-1:0] gnt_o,
    input logic [IDX_W-1:0]  gnt_idx_o,
    input logic              gnt_valid_o
);
    p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    p_valid_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_valid_o == (gnt_o != '0));

    p_idx_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_valid_o |-> gnt_o[gnt_idx_o]);

    p_grant_requested_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gnt_valid_o) |-> (($past(req_i) & gnt_o) != '0));

    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_valid_o && !xfer_done_i) |=> (gnt_valid_o && $stable(gnt_o) && $stable(gnt_idx_o)));

    p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_valid_o && xfer_done_i) |=> !gnt_valid_o);

    p_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gnt_valid_o && req_i == '0) |=> !gnt_valid_o);

    p_fixed_lowest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gnt_valid_o && req_i != '0 && !rotate_i)
            |=> (gnt_valid_o && (($past(req_i) & (gnt_o - NUM_CH'(1))) == '0)));
endmodule

bind dma_chan_arb dma_chan_arb_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_dma_chan_arb.sv
module tb_dma_chan_arb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       rotate = 1'b0;
    logic       done = 1'b0;
    logic [3:0] gnt;
    logic [1:0] gnt_idx;
    logic       gnt_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_chan_arb dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .rotate_i    (rotate),
        .xfer_done_i (done),
        .gnt_o       (gnt),
        .gnt_idx_o   (gnt_idx),
        .gnt_valid_o (gnt_valid)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // request, wait one edge, check that the grant went to exp
    task automatic serve_begin(input logic [3:0] r, input logic m, input int exp, input string tag);
        req = r;
        rotate = m;
        tick();
        check(int'(gnt_valid), 1, {tag, " valid (R9)"});
        check(int'(gnt_idx), exp, {tag, " index"});
        check(int'(gnt), 1 << exp, {tag, " one-hot (R9)"});
    endtask

    task automatic serve_end();
        req = '0;
        done = 1'b1;
        tick();
        done = 1'b0;
        check(int'(gnt_valid), 0, "grant released after done (R6)");
    endtask

    task automatic serve(input logic [3:0] r, input logic m, input int exp, input string tag);
        serve_begin(r, m, exp, tag);
        serve_end();
    endtask

    task automatic t_reset();
        check(int'(gnt), 0, "R1 grant at reset");
        check(int'(gnt_valid), 0, "R1 valid at reset");
        check(int'(gnt_idx), 0, "R1 index at reset");
    endtask

    task automatic t_no_req();
        req = '0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(int'(gnt_valid), 0, "R7 no grant without requests");
        end
    endtask

    task automatic t_first_rotate();
        serve(4'b1111, 1'b1, 0, "R4 first rotating pick");
    endtask

    task automatic t_rotate();
        serve(4'b1111, 1'b1, 1, "R3 after ch0");
        serve(4'b1111, 1'b1, 2, "R3 after ch1");
        serve(4'b1111, 1'b1, 3, "R3 after ch2");
        serve(4'b1111, 1'b1, 0, "R3 after ch3 wrap");
        serve(4'b0101, 1'b1, 2, "R3 skip idle ch1");
        serve(4'b0011, 1'b1, 0, "R3 wrap past ch3");
        serve(4'b0001, 1'b1, 0, "R3 sole requester is last");
    endtask

    task automatic t_fixed();
        serve(4'b1111, 1'b0, 0, "R2 all requesting");
        serve(4'b1110, 1'b0, 1, "R2 ch1 top");
        serve(4'b1100, 1'b0, 2, "R2 ch2 top");
        serve(4'b1000, 1'b0, 3, "R2 ch3 alone");
        serve(4'b1010, 1'b0, 1, "R2 pointer ignored");
    endtask

    task automatic t_hold();
        serve_begin(4'b1000, 1'b1, 3, "R6 start");
        for (int i = 0; i < 3; i++) begin
            req = 4'b0001 << i;
            rotate = i[0];
            tick();
            check(int'(gnt_idx), 3, "R6 index held");
            check(int'(gnt), 4'b1000, "R6 grant held");
        end
        serve_end();
    endtask

    task automatic t_done_idle();
        // last served is 3; a stray done while idle must not move the pointer
        req = '0;
        done = 1'b1;
        tick();
        done = 1'b0;
        check(int'(gnt_valid), 0, "R5 no grant on idle done");
        serve(4'b1111, 1'b1, 0, "R5 pointer kept after idle done");
    endtask

    task automatic t_mode_switch();
        serve(4'b0100, 1'b0, 2, "R8 fixed serve ch2");
        serve(4'b1111, 1'b1, 3, "R8 rotate after fixed ch2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_no_req();
        t_first_rotate();
        t_rotate();
        t_fixed();
        t_hold();
        t_done_idle();
        t_mode_switch();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule